// File: doc/BRIEF.md
# USB Host Endpoint Polling Controller

This block sequences the transactions of one software-driven host endpoint. Software programs the endpoint kind (bulk or interrupt), a NAK retry interval and an optional NAK give-up rule, then pulses a start strobe. The controller asks a packet engine for one transaction at a time and waits for the handshake outcome: ACK, NAK, STALL or a response timeout.

The transfer kind decides what happens next. An interrupt-kind run makes exactly one handshake and halts whatever the answer was. A bulk-kind run retries each NAK on its own after a programmable interval, measured in ticks of an external microsecond or start-of-frame pulse. It stops on ACK, on STALL, on a response timeout, or when the optional NAK count or elapsed-time limit is reached. A software stop request never cuts a transaction short: it is held until the current handshake has come back, or takes effect at once while the controller is waiting out the retry interval.

States: `ST_IDLE` (not busy), `ST_ISSUE` (request pulse to the packet engine), `ST_WAIT_HS` (transaction in flight), `ST_BACKOFF` (retry interval running). Transitions: IDLE→ISSUE on an accepted start. ISSUE→WAIT_HS always. WAIT_HS→IDLE on ACK, STALL, timeout, any interrupt-kind NAK, a bulk NAK that reaches the count limit, or a bulk NAK with a stop pending. WAIT_HS→BACKOFF on any other bulk NAK. BACKOFF→IDLE on a stop request or an elapsed-time hit. BACKOFF→ISSUE when the interval counter is zero.

Top module: `ep_poll_ctrl`

## Requirements
- R1: After reset, busy_o, req_o, done_irq_o, nak_stop_irq_o, nak_seen_o, stall_seen_o, xact_err_o and start_err_o are 0 and last_hs_o is 2'b00.
- R2: A start_i pulse sampled while idle makes busy_o and req_o rise together after that edge. req_o is high for exactly one cycle per transaction. The start clears nak_seen_o, stall_seen_o and xact_err_o.
- R3: With ep_bulk_i=0 latched at start, the first handshake (ACK or NAK) ends the run: busy_o falls and done_irq_o pulses for one cycle after the handshake edge, and no further req_o follows.
- R4: A bulk NAK loads the interval counter with nak_ivl_i. The counter counts down by one on each tick_i cycle spent in ST_BACKOFF. The next req_o comes the cycle after the counter is seen at zero, so an interval of 0 retries two cycles after the NAK.
- R5: hs_code_i uses 2'b00 ACK, 2'b01 NAK, 2'b10 STALL, 2'b11 timeout. An ACK completes a run of either kind with a done_irq_o pulse. last_hs_o holds the code of the last handshake, and nak_seen_o is set by any NAK of the run.
- R6: With nak_lim_en_i=1 and nak_lim_i nonzero, the bulk NAK that brings the run's NAK count to nak_lim_i halts the run. That NAK pulses nak_stop_irq_o and does not pulse done_irq_o.
- R7: With nak_lim_en_i=1 and nak_tmo_i nonzero, ST_BACKOFF halts the run with a nak_stop_irq_o pulse once the ticks counted since the start reach nak_tmo_i.
- R8: A stop_i pulse while busy is held until a boundary. A handshake in flight is still taken and recorded, and an ACK still completes. A later bulk NAK, or ST_BACKOFF, ends the run with busy_o falling and no interrupt pulse. A stop_i while idle has no effect.
- R9: A STALL handshake ends the run, sets stall_seen_o and pulses done_irq_o.
- R10: A timeout handshake ends the run, sets xact_err_o and pulses done_irq_o with no retry.
- R11: A start_i while busy is ignored: no extra req_o and the run goes on unchanged. It sets start_err_o, which stays set until reset.
- R12: done_irq_o and nak_stop_irq_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Software start strobe |
| stop_i | input | 1 | Software stop request |
| ep_bulk_i | input | 1 | 1 = bulk kind, 0 = interrupt kind (latched at start) |
| nak_ivl_i | input | IVL_W | NAK retry interval in ticks |
| nak_lim_en_i | input | 1 | Enables the NAK give-up rule |
| nak_lim_i | input | CNT_W | NAK count limit, 0 = no count limit |
| nak_tmo_i | input | TMO_W | Elapsed tick limit, 0 = no time limit |
| tick_i | input | 1 | Microsecond or start-of-frame tick |
| req_o | output | 1 | One-cycle transaction request to the packet engine |
| hs_valid_i | input | 1 | Handshake outcome valid |
| hs_code_i | input | 2 | Handshake outcome code |
| busy_o | output | 1 | Run in progress |
| done_irq_o | output | 1 | Transaction-complete interrupt pulse |
| nak_stop_irq_o | output | 1 | Stopped-on-NAK interrupt pulse |
| nak_seen_o | output | 1 | A NAK was received in this run |
| stall_seen_o | output | 1 | STALL received |
| xact_err_o | output | 1 | Response timeout received |
| start_err_o | output | 1 | Sticky start-while-busy flag |
| last_hs_o | output | 2 | Code of the last handshake |

## Verification
The bench builds the controller with IVL_W=4, CNT_W=3 and TMO_W=6. With these widths the interval, the NAK count limit and the elapsed-tick limit are all hit within a few dozen cycles, so count and time give-ups, zero-interval retries and long intervals all fit in a short run. The tick comes every third cycle, so the retry timing depends on tick phase as well as on the programmed value.

// File: rtl/ep_poll_pkg.sv
package ep_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_WAIT_HS = 2'd2,
        ST_BACKOFF = 2'd3
    } ep_state_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10,
        HS_TMO   = 2'b11
    } hs_code_e;

endpackage

// File: rtl/ep_poll_timer.sv
module ep_poll_timer #(
    parameter int IVL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IVL_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             zero_o
);

    logic [IVL_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ep_nak_guard.sv
module ep_nak_guard #(
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             busy_i,
    input  logic             tick_i,
    input  logic             nak_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             cnt_hit_o,
    output logic             time_hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [TMO_W-1:0] TMO_MAX = {TMO_W{1'b1}};

    logic [CNT_W-1:0] nak_cnt_q;
    logic [TMO_W-1:0] elapsed_q;
    logic [CNT_W:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nak_cnt_q <= '0;
            elapsed_q <= '0;
        end else if (clr_i) begin
            nak_cnt_q <= '0;
            elapsed_q <= '0;
        end else begin
            if (nak_i && (nak_cnt_q != CNT_MAX)) begin
                nak_cnt_q <= nak_cnt_q + 1'b1;
            end
            if (busy_i && tick_i && (elapsed_q != TMO_MAX)) begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    assign cnt_next   = {1'b0, nak_cnt_q} + 1'b1;
    assign cnt_hit_o  = en_i && (lim_i != '0) && (cnt_next >= {1'b0, lim_i});
    assign time_hit_o = en_i && (tmo_i != '0) && (elapsed_q >= tmo_i);

    // R7
    elapsed_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (elapsed_q >= $past(elapsed_q)));

endmodule

// File: rtl/ep_poll_ctrl.sv
module ep_poll_ctrl
    import ep_poll_pkg::*;
#(
    parameter int IVL_W = 10,
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             ep_bulk_i,
    input  logic [IVL_W-1:0] nak_ivl_i,
    input  logic             nak_lim_en_i,
    input  logic [CNT_W-1:0] nak_lim_i,
    input  logic [TMO_W-1:0] nak_tmo_i,
    input  logic             tick_i,
    output logic             req_o,
    input  logic             hs_valid_i,
    input  logic [1:0]       hs_code_i,
    output logic             busy_o,
    output logic             done_irq_o,
    output logic             nak_stop_irq_o,
    output logic             nak_seen_o,
    output logic             stall_seen_o,
    output logic             xact_err_o,
    output logic             start_err_o,
    output logic [1:0]       last_hs_o
);

    ep_state_e state_q, state_d;
    hs_code_e  hs_code;
    logic      bulk_q;
    logic      stop_pend_q;
    logic      stop_now;
    logic      accept_start;
    logic      ev_done, ev_nakstop;
    logic      load_timer, nak_bulk;
    logic      timer_zero, cnt_hit, time_hit;

    assign hs_code      = hs_code_e'(hs_code_i);
    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign stop_now     = stop_pend_q || stop_i;
    assign busy_o       = (state_q != ST_IDLE);
    assign req_o        = (state_q == ST_ISSUE);

    ep_poll_timer #(.IVL_W(IVL_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_timer),
        .load_val_i (nak_ivl_i),
        .run_i      (state_q == ST_BACKOFF),
        .tick_i     (tick_i),
        .zero_o     (timer_zero)
    );

    ep_nak_guard #(.CNT_W(CNT_W), .TMO_W(TMO_W)) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept_start),
        .busy_i     (busy_o),
        .tick_i     (tick_i),
        .nak_i      (nak_bulk),
        .en_i       (nak_lim_en_i),
        .lim_i      (nak_lim_i),
        .tmo_i      (nak_tmo_i),
        .cnt_hit_o  (cnt_hit),
        .time_hit_o (time_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and events
    always_comb begin
        state_d    = state_q;
        ev_done    = 1'b0;
        ev_nakstop = 1'b0;
        load_timer = 1'b0;
        nak_bulk   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                state_d = ST_WAIT_HS;
            end
            ST_WAIT_HS: begin
                if (hs_valid_i) begin
                    if (hs_code != HS_NAK) begin
                        ev_done = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!bulk_q) begin
                        ev_done = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        nak_bulk = 1'b1;
                        if (cnt_hit) begin
                            ev_nakstop = 1'b1;
                            state_d    = ST_IDLE;
                        end else if (stop_now) begin
                            state_d = ST_IDLE;
                        end else begin
                            load_timer = 1'b1;
                            state_d    = ST_BACKOFF;
                        end
                    end
                end
            end
            ST_BACKOFF: begin
                if (stop_now) begin
                    state_d = ST_IDLE;
                end else if (time_hit) begin
                    ev_nakstop = 1'b1;
                    state_d    = ST_IDLE;
                end else if (timer_zero) begin
                    state_d = ST_ISSUE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_irq_o     <= 1'b0;
            nak_stop_irq_o <= 1'b0;
            nak_seen_o     <= 1'b0;
            stall_seen_o   <= 1'b0;
            xact_err_o     <= 1'b0;
            start_err_o    <= 1'b0;
            last_hs_o      <= HS_ACK;
            bulk_q         <= 1'b0;
            stop_pend_q    <= 1'b0;
        end else begin
            done_irq_o     <= ev_done;
            nak_stop_irq_o <= ev_nakstop;
            if (start_i && busy_o) begin
                start_err_o <= 1'b1;
            end
            if (accept_start) begin
                bulk_q       <= ep_bulk_i;
                stop_pend_q  <= 1'b0;
                nak_seen_o   <= 1'b0;
                stall_seen_o <= 1'b0;
                xact_err_o   <= 1'b0;
            end else if (state_q == ST_IDLE) begin
                stop_pend_q <= 1'b0;
            end else if (stop_i) begin
                stop_pend_q <= 1'b1;
            end
            if ((state_q == ST_WAIT_HS) && hs_valid_i) begin
                last_hs_o <= hs_code_i;
                unique case (hs_code)
                    HS_ACK:   ;
                    HS_NAK:   nak_seen_o   <= 1'b1;
                    HS_STALL: stall_seen_o <= 1'b1;
                    HS_TMO:   xact_err_o   <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R3
    intr_one_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_HS) && hs_valid_i && !bulk_q) |=> !busy_o);

    // R8
    no_abort_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_HS) && !hs_valid_i) |=> (state_q == ST_WAIT_HS));

    // R11
    start_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |=> start_err_o);

    // R12
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_irq_o && nak_stop_irq_o));

    // R9
    stall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_HS) && hs_valid_i && (hs_code_i == 2'b10)) |=> (stall_seen_o && done_irq_o));

endmodule

// File: tb/test_ep_poll_ctrl.sv
module test_ep_poll_ctrl;

    localparam int IVL_W = 4;
    localparam int CNT_W = 3;
    localparam int TMO_W = 6;
    localparam int CNT_SAT = (1 << CNT_W) - 1;
    localparam int TMO_SAT = (1 << TMO_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, ep_bulk_i = 1'b0;
    logic [IVL_W-1:0] nak_ivl_i = '0;
    logic nak_lim_en_i = 1'b0;
    logic [CNT_W-1:0] nak_lim_i = '0;
    logic [TMO_W-1:0] nak_tmo_i = '0;
    logic tick_i = 1'b0;
    logic req_o, hs_valid_i = 1'b0;
    logic [1:0] hs_code_i = 2'b00;
    logic busy_o, done_irq_o, nak_stop_irq_o, nak_seen_o, stall_seen_o;
    logic xact_err_o, start_err_o;
    logic [1:0] last_hs_o;

    always #2.5 clk = ~clk;

    ep_poll_ctrl #(.IVL_W(IVL_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) i_ep_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .ep_bulk_i(ep_bulk_i), .nak_ivl_i(nak_ivl_i), .nak_lim_en_i(nak_lim_en_i),
        .nak_lim_i(nak_lim_i), .nak_tmo_i(nak_tmo_i), .tick_i(tick_i),
        .req_o(req_o), .hs_valid_i(hs_valid_i), .hs_code_i(hs_code_i),
        .busy_o(busy_o), .done_irq_o(done_irq_o), .nak_stop_irq_o(nak_stop_irq_o),
        .nak_seen_o(nak_seen_o), .stall_seen_o(stall_seen_o), .xact_err_o(xact_err_o),
        .start_err_o(start_err_o), .last_hs_o(last_hs_o)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- tick source and handshake responder ----------------
    int tick_ph = 0;
    always @(negedge clk) begin
        tick_i = (tick_ph == 0);
        tick_ph = (tick_ph == 2) ? 0 : tick_ph + 1;
    end

    int resp_q[$];
    int pend = 0;
    int n_req = 0;
    always @(negedge clk) begin
        hs_valid_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                hs_valid_i = 1'b1;
                hs_code_i = (resp_q.size() > 0) ? 2'(resp_q.pop_front()) : 2'b00;
            end
        end
        if (req_o) begin
            pend = 2;
            n_req++;
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_st = 0;           // 0 idle, 1 issue, 2 waiting, 3 backoff
    int m_tmr = 0, m_naks = 0, m_ticks = 0;
    bit m_bulk = 0, m_stop = 0;
    bit e_done = 0, e_nakstop = 0, e_nak = 0, e_stall = 0, e_err = 0, e_serr = 0;
    int e_last = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_naks = 0; m_ticks = 0; m_bulk = 0; m_stop = 0;
            e_done = 0; e_nakstop = 0; e_nak = 0; e_stall = 0; e_err = 0; e_serr = 0;
            e_last = 0;
        end else begin
            int old_st;
            int old_ticks;
            bit halt_stop;
            old_st = m_st;
            old_ticks = m_ticks;
            halt_stop = m_stop || stop_i;
            e_done = 0;
            e_nakstop = 0;
            if (start_i && old_st != 0) e_serr = 1;
            case (old_st)
                0: if (start_i) begin
                    m_st = 1; m_bulk = ep_bulk_i;
                    e_nak = 0; e_stall = 0; e_err = 0;
                end
                1: m_st = 2;
                2: if (hs_valid_i) begin
                    e_last = hs_code_i;
                    if (hs_code_i == 1) e_nak = 1;
                    if (hs_code_i == 2) e_stall = 1;
                    if (hs_code_i == 3) e_err = 1;
                    if (hs_code_i != 1 || !m_bulk) begin
                        e_done = 1; m_st = 0;
                    end else begin
                        if (nak_lim_en_i && nak_lim_i != 0 && m_naks + 1 >= nak_lim_i) begin
                            e_nakstop = 1; m_st = 0;
                        end else if (halt_stop) begin
                            m_st = 0;
                        end else begin
                            m_tmr = nak_ivl_i; m_st = 3;
                        end
                        if (m_naks < CNT_SAT) m_naks++;
                    end
                end
                default: begin
                    if (halt_stop) m_st = 0;
                    else if (nak_lim_en_i && nak_tmo_i != 0 && old_ticks >= nak_tmo_i) begin
                        e_nakstop = 1; m_st = 0;
                    end else if (m_tmr == 0) m_st = 1;
                    else if (tick_i) m_tmr--;
                end
            endcase
            if (old_st == 0) begin
                m_stop = 0;
                if (start_i) begin m_naks = 0; m_ticks = 0; end
            end else begin
                if (stop_i) m_stop = 1;
                if (tick_i && m_ticks < TMO_SAT) m_ticks++;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    bit seen_done = 0, seen_nakstop = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = 0;
            n_run++;
            if (busy_o !== (m_st != 0)) begin bad = 1; $display("FAIL R2 busy_o: actual %0b expected %0b", busy_o, m_st != 0); end
            if (req_o !== (m_st == 1)) begin bad = 1; $display("FAIL R4 req_o: actual %0b expected %0b", req_o, m_st == 1); end
            if (done_irq_o !== e_done) begin bad = 1; $display("FAIL R5 done_irq_o: actual %0b expected %0b", done_irq_o, e_done); end
            if (nak_stop_irq_o !== e_nakstop) begin bad = 1; $display("FAIL R6 nak_stop_irq_o: actual %0b expected %0b", nak_stop_irq_o, e_nakstop); end
            if (nak_seen_o !== e_nak) begin bad = 1; $display("FAIL R5 nak_seen_o: actual %0b expected %0b", nak_seen_o, e_nak); end
            if (stall_seen_o !== e_stall) begin bad = 1; $display("FAIL R9 stall_seen_o: actual %0b expected %0b", stall_seen_o, e_stall); end
            if (xact_err_o !== e_err) begin bad = 1; $display("FAIL R10 xact_err_o: actual %0b expected %0b", xact_err_o, e_err); end
            if (start_err_o !== e_serr) begin bad = 1; $display("FAIL R11 start_err_o: actual %0b expected %0b", start_err_o, e_serr); end
            if (last_hs_o !== 2'(e_last)) begin bad = 1; $display("FAIL R5 last_hs_o: actual %0d expected %0d", last_hs_o, e_last); end
            if (bad) n_fail++;
            if (done_irq_o) seen_done = 1;
            if (nak_stop_irq_o) seen_nakstop = 1;
        end
    end

    // ---------------- scenario helpers ----------------
    task automatic setup(bit bulk, int ivl, bit en, int lim, int tmo);
        ep_bulk_i = bulk;
        nak_ivl_i = IVL_W'(ivl);
        nak_lim_en_i = en;
        nak_lim_i = CNT_W'(lim);
        nak_tmo_i = TMO_W'(tmo);
        resp_q.delete();
        n_req = 0;
        seen_done = 0;
        seen_nakstop = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_o && guard < 2000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", busy_o, 0, "busy after reset");
        chk("R1", req_o, 0, "req after reset");
        chk("R1", {done_irq_o, nak_stop_irq_o, nak_seen_o, stall_seen_o, xact_err_o, start_err_o}, 0, "flags after reset");
        chk("R1", last_hs_o, 0, "last_hs after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: stop while idle has no effect
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        chk("R8", busy_o, 0, "stop while idle");

        // R3 / R5: interrupt kind, ACK
        setup(0, 3, 0, 0, 0);
        resp_q.push_back(0);
        pulse_start();
        chk("R2", busy_o, 1, "busy after start");
        wait_idle();
        chk("R3", n_req, 1, "interrupt ACK request count");
        chk("R5", seen_done, 1, "interrupt ACK done irq");

        // R3: interrupt kind, NAK halts after one handshake
        setup(0, 3, 0, 0, 0);
        resp_q.push_back(1);
        pulse_start();
        wait_idle();
        chk("R3", n_req, 1, "interrupt NAK request count");
        chk("R3", seen_done, 1, "interrupt NAK done irq");
        chk("R3", nak_seen_o, 1, "interrupt NAK status");

        // R4: bulk retries with interval 2, then ACK
        setup(1, 2, 0, 0, 0);
        resp_q = '{1, 1, 0};
        pulse_start();
        wait_idle();
        chk("R4", n_req, 3, "bulk retry request count");
        chk("R5", last_hs_o, 0, "bulk final code ACK");
        chk("R5", nak_seen_o, 1, "bulk NAK recorded");

        // R4: zero interval
        setup(1, 0, 0, 0, 0);
        resp_q = '{1, 1, 1, 0};
        pulse_start();
        wait_idle();
        chk("R4", n_req, 4, "zero interval request count");

        // R6: count give-up after 3 NAKs
        setup(1, 1, 1, 3, 0);
        repeat (10) resp_q.push_back(1);
        pulse_start();
        wait_idle();
        chk("R6", n_req, 3, "NAK count limit requests");
        chk("R6", seen_nakstop, 1, "NAK count stop irq");
        chk("R6", seen_done, 0, "no done on NAK count stop");

        // R7: elapsed-time give-up
        setup(1, 4, 1, 0, 6);
        repeat (20) resp_q.push_back(1);
        pulse_start();
        wait_idle();
        chk("R7", seen_nakstop, 1, "time limit stop irq");
        chk("R7", busy_o, 0, "idle after time limit");

        // R9: STALL
        setup(1, 1, 0, 0, 0);
        resp_q = '{1, 2};
        pulse_start();
        wait_idle();
        chk("R9", stall_seen_o, 1, "stall flag");
        chk("R9", n_req, 2, "stall request count");

        // R10: response timeout
        setup(1, 1, 0, 0, 0);
        resp_q = '{3};
        pulse_start();
        wait_idle();
        chk("R10", xact_err_o, 1, "timeout error flag");
        chk("R10", n_req, 1, "timeout no retry");
        chk("R10", seen_done, 1, "timeout done irq");

        // R8: stop during a transaction, NAK answer -> halt, no retry, no irq
        setup(1, 1, 0, 0, 0);
        repeat (5) resp_q.push_back(1);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk("R8", busy_o, 1, "in-flight transaction not aborted");
        wait_idle();
        chk("R8", n_req, 1, "stop prevents retry");
        chk("R8", nak_seen_o, 1, "in-flight NAK recorded");
        chk("R8", seen_done + seen_nakstop, 0, "no irq on stop");

        // R8: stop during a transaction, ACK answer still completes
        setup(1, 1, 0, 0, 0);
        resp_q = '{0};
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        wait_idle();
        chk("R8", seen_done, 1, "ACK after stop completes");

        // R8: stop during backoff halts at once
        setup(1, 15, 0, 0, 0);
        repeat (5) resp_q.push_back(1);
        pulse_start();
        repeat (8) @(negedge clk);
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        @(negedge clk);
        chk("R8", busy_o, 0, "stop in backoff");
        chk("R8", n_req, 1, "no retry after backoff stop");

        // R11: start while busy
        setup(1, 2, 0, 0, 0);
        resp_q = '{1, 0};
        pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_idle();
        chk("R11", start_err_o, 1, "start while busy flag");
        chk("R11", n_req, 2, "start while busy ignored");

        // R2: new start clears per-run flags; R11 flag stays
        setup(0, 0, 0, 0, 0);
        resp_q = '{0};
        pulse_start();
        chk("R2", nak_seen_o, 0, "start clears NAK status");
        wait_idle();
        chk("R11", start_err_o, 1, "start error sticky");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule